// File: doc/BRIEF.md
# Silicon Strip Event Stream Parser

This block sits between a strip-readout input buffer and a clustering stage. It takes 18-bit input words. Each word holds two status bits and two payload bytes. The block walks the payload bytes one per clock, high byte first, through a small event grammar:

- A three-byte header carries a sequence number, a readout-board identifier and a chip identifier.
- The header is followed by strip/amplitude byte pairs.
- The byte 0xC0, standing where a strip number is expected, closes the event.

Each completed pair, and each event close, leaves the block as one 23-bit tagged word on a valid/ready output.

A select input picks the byte source. It is either the live detector port or a test port fed from a local pattern memory; the port not selected is never acknowledged. A header byte that shows up before the closing marker shuts the open event with an end word, and then starts the new event. The select should only be changed between input words.

Top module: `strip_event_parser`

## Requirements
- R1: Input word bits 17..16 are status (error) bits, bits 15..8 the first byte and bits 7..0 the second byte. Bytes are parsed in that order, and a word is acknowledged in the cycle its second byte is taken.
- R2: The first three bytes of an event are sequence number, board identifier and chip identifier. They produce no output, and the chip identifier's low 4 bits are kept for the event.
- R3: In the strip slot, a byte with bit 7 clear is a strip number (its bits 6..0 are kept). The following byte, of any value including 0xC0, is its amplitude, and the pair is emitted as one data word.
- R4: Output word layout: bits 22..21 data type, bit 20 first-word flag, bit 19 end flag, bits 18..11 amplitude, bits 10..7 chip identifier, bits 6..0 strip number.
- R5: The first-word flag is 1 only on the first data word after a header, and 0 on all other words.
- R6: A 0xC0 byte in the strip slot emits an end word and returns to header parsing. The end word has the end flag at 1, the amplitude, strip and first-word flag at 0, and the event's chip identifier.
- R7: A byte with bit 7 set, other than 0xC0, in the strip slot emits an end word for the open event and is itself taken as the next event's sequence number.
- R8: A 0xC0 byte where a sequence number is expected is consumed with no output.
- R9: The data type of each emitted word is the OR of the status bits of every input word that supplied a byte since the previous emitted word. The value 00 means clean, and a word with status set is still emitted.
- R10: While output valid is high and output ready is low, the output word holds stable. No byte is taken that would need the output slot, and no word or byte is lost.
- R11: With the select high only the test port is read and acknowledged. The live port's ready stays 0 and its data has no effect; with the select low the roles swap.
- R12: Reset clears output valid and any partly parsed event, so the next byte is taken as a sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| liveWord | input | 18 | Detector input word (status, byte 1, byte 2) |
| liveValid | input | 1 | Detector word present |
| liveReady | output | 1 | Detector word consumed this cycle |
| testWord | input | 18 | Test-pattern input word |
| testValid | input | 1 | Test word present |
| testReady | output | 1 | Test word consumed this cycle |
| testSel | input | 1 | 1 selects the test port, 0 the detector port |
| outWord | output | 23 | Tagged strip word |
| outValid | output | 1 | Output word present |
| outReady | input | 1 | Downstream accepts the output word |

## Verification
The stream is built to hit each grammar corner:

- **Amplitude of 0xC0.** A parser that tests for the end marker regardless of slot would close the event early and lose a strip.
- **Early header, then an immediate close.** Dropping the forced end word, or swallowing the header byte that triggered it, shifts every later header field into the wrong place.
- **Stray marker while idle, and a chip byte with high nibble bits.** A parser that handles either wrongly emits a phantom word or a corrupted chip field.
- **Status bits on the chip byte and on a shared word.** These show whether error codes stick until the next emitted word rather than leaking or vanishing.
- **Replay from the test port.** The same stream is replayed with output ready pulsing once every three cycles and junk held on the detector port, and a reset lands mid-header first. A design that lost bytes under back-pressure, leaked the unselected port, or kept stale header state would give a different word sequence.

// File: rtl/sep_pkg.sv
package sep_pkg;

  typedef enum logic [2:0] {
    ST_SEQ   = 3'd0,
    ST_BOARD = 3'd1,
    ST_CHIP  = 3'd2,
    ST_STRIP = 3'd3,
    ST_AMP   = 3'd4
  } parseState_t;

  // strobes from control to datapath, all qualified by take
  typedef struct packed {
    logic take;
    logic latchChip;
    logic latchStrip;
    logic emitData;
    logic emitEnd;
  } ctlStrobe_t;

endpackage

// File: rtl/sep_ctrl.sv
module sep_ctrl
  import sep_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] END_CODE = 8'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] curByte,
  input  logic              curValid,
  input  logic              slotFree,
  output logic              lowSel,
  output ctlStrobe_t        strobe
);

  parseState_t stateQ, stateD;
  logic        lowQ;
  logic        isEnd, isHead, needSlot, go;
  logic        wantChip, wantStrip, wantData, wantEnd;

  assign isEnd  = (curByte == END_CODE);
  assign isHead = curByte[BYTE_W-1] && !isEnd;
  assign lowSel = lowQ;

  always_comb begin
    stateD    = stateQ;
    needSlot  = 1'b0;
    wantChip  = 1'b0;
    wantStrip = 1'b0;
    wantData  = 1'b0;
    wantEnd   = 1'b0;
    unique case (stateQ)
      ST_SEQ:   stateD = isEnd ? ST_SEQ : ST_BOARD;
      ST_BOARD: stateD = ST_CHIP;
      ST_CHIP: begin
        wantChip = 1'b1;
        stateD   = ST_STRIP;
      end
      ST_STRIP: begin
        if (isEnd) begin
          wantEnd  = 1'b1;
          needSlot = 1'b1;
          stateD   = ST_SEQ;
        end else if (isHead) begin
          wantEnd  = 1'b1;
          needSlot = 1'b1;
          stateD   = ST_BOARD;
        end else begin
          wantStrip = 1'b1;
          stateD    = ST_AMP;
        end
      end
      ST_AMP: begin
        wantData = 1'b1;
        needSlot = 1'b1;
        stateD   = ST_STRIP;
      end
      default: stateD = ST_SEQ;
    endcase
  end

  assign go = curValid && (!needSlot || slotFree);

  always_comb begin
    strobe.take       = go;
    strobe.latchChip  = go && wantChip;
    strobe.latchStrip = go && wantStrip;
    strobe.emitData   = go && wantData;
    strobe.emitEnd    = go && wantEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_SEQ;
      lowQ   <= 1'b0;
    end else if (go) begin
      stateQ <= stateD;
      lowQ   <= !lowQ;
    end
  end

endmodule

// File: rtl/sep_datapath.sv
module sep_datapath
  import sep_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int ERR_W   = 2,
  parameter int CHIP_W  = 4,
  parameter int STRIP_W = 7,
  localparam int IN_W   = ERR_W + 2 * BYTE_W,
  localparam int OUT_W  = ERR_W + 2 + BYTE_W + CHIP_W + STRIP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IN_W-1:0]   liveWord,
  input  logic              liveValid,
  output logic              liveReady,
  input  logic [IN_W-1:0]   testWord,
  input  logic              testValid,
  output logic              testReady,
  input  logic              testSel,
  input  logic              lowSel,
  input  ctlStrobe_t        strobe,
  output logic [BYTE_W-1:0] curByte,
  output logic              curValid,
  output logic              slotFree,
  output logic [OUT_W-1:0]  outWord,
  output logic              outValid,
  input  logic              outReady
);

  logic [IN_W-1:0]    selWord;
  logic [ERR_W-1:0]   curErr, errQ, errNow;
  logic [CHIP_W-1:0]  chipQ;
  logic [STRIP_W-1:0] stripQ;
  logic               firstQ;
  logic               wordDone, emitAny;
  logic [OUT_W-1:0]   wordQ;
  logic               validQ;

  assign selWord  = testSel ? testWord : liveWord;
  assign curValid = testSel ? testValid : liveValid;
  assign curByte  = lowSel ? selWord[BYTE_W-1:0] : selWord[2*BYTE_W-1:BYTE_W];
  assign curErr   = selWord[IN_W-1:2*BYTE_W];

  assign wordDone  = strobe.take && lowSel;
  assign liveReady = wordDone && !testSel;
  assign testReady = wordDone && testSel;

  assign errNow   = errQ | (strobe.take ? curErr : '0);
  assign emitAny  = strobe.emitData || strobe.emitEnd;
  assign slotFree = !validQ || outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ   <= '0;
      chipQ  <= '0;
      stripQ <= '0;
      firstQ <= 1'b0;
    end else begin
      if (emitAny)          errQ <= '0;
      else if (strobe.take) errQ <= errNow;
      if (strobe.latchChip) begin
        chipQ  <= curByte[CHIP_W-1:0];
        firstQ <= 1'b1;
      end else if (emitAny) begin
        firstQ <= 1'b0;
      end
      if (strobe.latchStrip) stripQ <= curByte[STRIP_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      wordQ  <= '0;
    end else if (strobe.emitData) begin
      validQ <= 1'b1;
      wordQ  <= {errNow, firstQ, 1'b0, curByte, chipQ, stripQ};
    end else if (strobe.emitEnd) begin
      validQ <= 1'b1;
      wordQ  <= {errNow, 1'b0, 1'b1, {BYTE_W{1'b0}}, chipQ, {STRIP_W{1'b0}}};
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  assign outWord  = wordQ;
  assign outValid = validQ;

endmodule

// File: rtl/strip_event_parser.sv
module strip_event_parser
  import sep_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int ERR_W   = 2,
  parameter int CHIP_W  = 4,
  parameter int STRIP_W = 7,
  parameter logic [BYTE_W-1:0] END_CODE = 8'hC0,
  localparam int IN_W   = ERR_W + 2 * BYTE_W,
  localparam int OUT_W  = ERR_W + 2 + BYTE_W + CHIP_W + STRIP_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IN_W-1:0]  liveWord,
  input  logic             liveValid,
  output logic             liveReady,
  input  logic [IN_W-1:0]  testWord,
  input  logic             testValid,
  output logic             testReady,
  input  logic             testSel,
  output logic [OUT_W-1:0] outWord,
  output logic             outValid,
  input  logic             outReady
);

  ctlStrobe_t        strobe;
  logic              lowSel;
  logic [BYTE_W-1:0] curByte;
  logic              curValid;
  logic              slotFree;

  sep_ctrl #(
    .BYTE_W  (BYTE_W),
    .END_CODE(END_CODE)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .curByte (curByte),
    .curValid(curValid),
    .slotFree(slotFree),
    .lowSel  (lowSel),
    .strobe  (strobe)
  );

  sep_datapath #(
    .BYTE_W (BYTE_W),
    .ERR_W  (ERR_W),
    .CHIP_W (CHIP_W),
    .STRIP_W(STRIP_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .liveWord (liveWord),
    .liveValid(liveValid),
    .liveReady(liveReady),
    .testWord (testWord),
    .testValid(testValid),
    .testReady(testReady),
    .testSel  (testSel),
    .lowSel   (lowSel),
    .strobe   (strobe),
    .curByte  (curByte),
    .curValid (curValid),
    .slotFree (slotFree),
    .outWord  (outWord),
    .outValid (outValid),
    .outReady (outReady)
  );

endmodule

// File: rtl/sep_checker.sv
module sep_checker #(
  parameter int BYTE_W  = 8,
  parameter int ERR_W   = 2,
  parameter int CHIP_W  = 4,
  parameter int STRIP_W = 7,
  localparam int OUT_W  = ERR_W + 2 + BYTE_W + CHIP_W + STRIP_W,
  localparam int EOD_B  = BYTE_W + CHIP_W + STRIP_W,
  localparam int NEW_B  = EOD_B + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             liveValid,
  input logic             liveReady,
  input logic             testValid,
  input logic             testReady,
  input logic             testSel,
  input logic [OUT_W-1:0] outWord,
  input logic             outValid,
  input logic             outReady
);

  // R10
  held_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord)));

  // R10
  live_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    liveReady |-> liveValid);

  // R10
  test_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    testReady |-> testValid);

  // R11
  live_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    testSel |-> !liveReady);

  // R11
  test_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !testSel |-> !testReady);

  // R6
  end_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outWord[EOD_B]) |->
      (outWord[EOD_B-1:CHIP_W+STRIP_W] == '0 && outWord[STRIP_W-1:0] == '0));

  // R5
  first_not_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(outWord[NEW_B] && outWord[EOD_B]));

endmodule

bind strip_event_parser sep_checker #(
  .BYTE_W (BYTE_W),
  .ERR_W  (ERR_W),
  .CHIP_W (CHIP_W),
  .STRIP_W(STRIP_W)
) i_sep_checker (
  .clk      (clk),
  .rstN     (rstN),
  .liveValid(liveValid),
  .liveReady(liveReady),
  .testValid(testValid),
  .testReady(testReady),
  .testSel  (testSel),
  .outWord  (outWord),
  .outValid (outValid),
  .outReady (outReady)
);

// File: tb/test_strip_event_parser.sv
module test_strip_event_parser;

  localparam int N_IN  = 17;
  localparam int N_OUT = 11;

  // stimulus: {status, first byte, second byte}
  localparam logic [17:0] STIM [N_IN] = '{
    {2'b00, 8'hAA, 8'h12},  // seq, board
    {2'b00, 8'h07, 8'h05},  // chip 7, strip 05
    {2'b00, 8'h33, 8'h06},  // amp 33 -> A ; strip 06
    {2'b00, 8'hC0, 8'h40},  // amp C0 -> B ; strip 40
    {2'b10, 8'h7F, 8'hC0},  // amp 7F -> C ; close -> D
    {2'b00, 8'h91, 8'h22},  // seq, board
    {2'b01, 8'h0B, 8'h10},  // chip B (status 1), strip 10
    {2'b00, 8'h44, 8'h85},  // amp 44 -> E ; early header -> F
    {2'b00, 8'h23, 8'h0C},  // board, chip C
    {2'b00, 8'hC0, 8'h00},  // close -> G ; seq
    {2'b00, 8'h01, 8'h03},  // board, chip 3
    {2'b00, 8'h7F, 8'h5A},  // strip 7F, amp 5A -> H
    {2'b00, 8'hC0, 8'hC0},  // close -> I ; stray marker dropped
    {2'b00, 8'h55, 8'h66},  // seq, board
    {2'b00, 8'h2F, 8'h01},  // chip F (from 2F), strip 01
    {2'b00, 8'hFF, 8'hC0},  // amp FF -> J ; close -> K
    {2'b00, 8'h10, 8'h20}   // seq, board (left open for reset test)
  };

  // expected: {type, first, end, amp, chip, strip}
  localparam logic [22:0] EXPECT [N_OUT] = '{
    {2'd0, 1'b1, 1'b0, 8'h33, 4'h7, 7'h05},
    {2'd0, 1'b0, 1'b0, 8'hC0, 4'h7, 7'h06},
    {2'd2, 1'b0, 1'b0, 8'h7F, 4'h7, 7'h40},
    {2'd2, 1'b0, 1'b1, 8'h00, 4'h7, 7'h00},
    {2'd1, 1'b1, 1'b0, 8'h44, 4'hB, 7'h10},
    {2'd0, 1'b0, 1'b1, 8'h00, 4'hB, 7'h00},
    {2'd0, 1'b0, 1'b1, 8'h00, 4'hC, 7'h00},
    {2'd0, 1'b1, 1'b0, 8'h5A, 4'h3, 7'h7F},
    {2'd0, 1'b0, 1'b1, 8'h00, 4'h3, 7'h00},
    {2'd0, 1'b1, 1'b0, 8'hFF, 4'hF, 7'h01},
    {2'd0, 1'b0, 1'b1, 8'h00, 4'hF, 7'h00}
  };

  localparam string WHY [N_OUT] = '{
    "R3 R4 R5", "R3", "R9", "R6 R9", "R2 R9", "R7",
    "R6", "R1 R5", "R6", "R2 R8", "R6"
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] liveWord = '0;
  logic        liveValid = 1'b0;
  logic        liveReady;
  logic [17:0] testWord = '0;
  logic        testValid = 1'b0;
  logic        testReady;
  logic        testSel = 1'b0;
  logic [22:0] outWord;
  logic        outValid;
  logic        outReady = 1'b1;

  int          checks = 0;
  int          fails = 0;
  logic [22:0] got [32];
  int          gotN = 0;
  logic        takeLive = 1'b0, takeTest = 1'b0;
  logic        heldPrev = 1'b0;
  logic [22:0] wordPrev = '0;
  int          liveLeak = 0;
  bit          phase2 = 1'b0;
  bit          stallMode = 1'b0;
  int          stallCnt = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  strip_event_parser i_strip_event_parser (
    .clk(clk), .rstN(rstN),
    .liveWord(liveWord), .liveValid(liveValid), .liveReady(liveReady),
    .testWord(testWord), .testValid(testValid), .testReady(testReady),
    .testSel(testSel),
    .outWord(outWord), .outValid(outValid), .outReady(outReady)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    takeLive <= liveValid && liveReady;
    takeTest <= testValid && testReady;
    if (rstN && outValid && outReady && gotN < 32) begin
      got[gotN] <= outWord;
      gotN <= gotN + 1;
    end
    if (phase2 && liveReady) liveLeak <= liveLeak + 1;
    // R10: word held while stalled
    if (rstN && heldPrev) check(outValid && outWord == wordPrev, "R10 hold", {8'd0, outWord}, {8'd0, wordPrev});
    heldPrev <= rstN && outValid && !outReady;
    wordPrev <= outWord;
  end

  always @(negedge clk) begin
    stallCnt++;
    if (stallMode) outReady = (stallCnt % 3 == 2);
    else outReady = 1'b1;
  end

  task automatic pushWord(input bit useTest, input logic [17:0] w);
    @(negedge clk);
    if (useTest) begin testWord = w; testValid = 1'b1; end
    else begin liveWord = w; liveValid = 1'b1; end
    forever begin
      @(posedge clk);
      #1;
      if (useTest ? takeTest : takeLive) break;
    end
  endtask

  task automatic compareAll(input string tag);
    check(gotN == N_OUT, {"R1 R8 count ", tag}, gotN, N_OUT);
    for (int i = 0; i < N_OUT; i++)
      check(got[i] == EXPECT[i], {WHY[i], " ", tag}, {9'd0, got[i]}, {9'd0, EXPECT[i]});
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    check(!outValid, "R12 valid in reset", outValid, 0);
    check(!liveReady && !testReady, "R12 ready in reset", {liveReady, testReady}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid, "R12 valid after reset", outValid, 0);

    // phase 1: live port, free-flowing output
    for (int i = 0; i < N_IN; i++) pushWord(1'b0, STIM[i]);
    @(negedge clk);
    liveValid = 1'b0;
    repeat (10) @(negedge clk);
    compareAll("live");

    // reset mid-header, then replay through test port with back-pressure
    rstN = 1'b0;
    testSel = 1'b1;
    liveWord = {2'b11, 8'hC0, 8'h85};
    liveValid = 1'b1;
    repeat (2) @(negedge clk);
    check(!outValid, "R12 valid after mid-event reset", outValid, 0);
    rstN = 1'b1;
    gotN = 0;
    phase2 = 1'b1;
    stallMode = 1'b1;
    for (int i = 0; i < N_IN - 1; i++) pushWord(1'b1, STIM[i]);
    @(negedge clk);
    testValid = 1'b0;
    repeat (40) @(negedge clk);
    compareAll("test port stalled");
    check(liveLeak == 0, "R11 live ready while test selected", liveLeak, 0);
    stallMode = 1'b0;
    phase2 = 1'b0;
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule